// File: doc/BRIEF.md
# Multi-format I2S/TDM Serial Audio Transmitter

This block turns parallel audio samples into a one-wire serial stream with a word-select or frame-sync line. It is paced by a one-cycle bit tick from an external clock divider, and each tick moves the output one bit period forward. Four framing styles are supported: classic I2S, left-justified stereo, TDM with a one-bit data delay, and left-justified TDM. Samples arrive in channel order over a valid/ready handshake and are held one at a time in a single-entry buffer.

Each slot is filled at its first bit. If no sample is waiting at that point, the slot carries either zero or the previous word, and a one-cycle underrun pulse reports the slot number. In mono mode every odd slot repeats the word of the even slot before it, so only even slots take samples. A loopback path sends the serial output to the receive-side data line in place of the external input. Configuration is static and may change only while `enable` is low. Dropping `enable` flushes the buffer and parks both lines low.

Top module: `tdm_serial_tx`

## Requirements
- R1: Format codes are 0 = I2S, 1 = left-justified, 2 = TDM and 3 = left-justified TDM. In codes 0 and 2 each data bit appears one tick after its slot position, so a slot's MSB follows the frame boundary by one tick and the first bit after enable is 0. In codes 1 and 3 the MSB appears on the first tick of its slot. Both lines change only on a tick.
- R2: In stereo formats a frame has two slots. `frame_ws` is low during the left slot (slot 0) for code 0 and high during slot 0 for code 1.
- R3: In TDM formats `frame_ws` is set by `cfg_fsync`: 0 = high for all of slot 0, 1 = high for the first half of the frame's bit periods, 2 or 3 = high for the first bit period only.
- R4: Length codes 0..7 select 32, 24, 20, 18, 16, 16, 8 and 8 data bits. The sample sits in the low bits of `smp_data` and is sent MSB first. Upper input bits are ignored, and slot bits past the length are 0.
- R5: A slot is 24 bit periods when `cfg_slot24` is 1 and the length code is 1, 2 or 3. It is 32 bit periods in every other case.
- R6: A TDM frame has `cfg_slots_m1`+1 slots. Stereo formats ignore `cfg_slots_m1`.
- R7: A slot whose first bit finds the buffer empty carries zero when `cfg_hold_last` is 0, and the previously sent word when it is 1.
- R8: On such a slot, `underrun` pulses for one cycle together with that slot's first tick, and `underrun_slot` gives the slot number. No pulse occurs without a tick.
- R9: With `cfg_mono` set, odd slots repeat the word of the preceding even slot and take no sample, so underruns are reported only for even slots.
- R10: `loop_out` follows `ser_data` when `cfg_loop` is 1 and `loop_in` otherwise.
- R11: While `enable` is low (and after reset), `smp_ready`, `ser_data`, `frame_ws` and `underrun` are 0 and the buffer is empty. The next enable starts at slot 0, bit 0.
- R12: `smp_ready` is high exactly when the block is enabled and the one-entry buffer is empty. Samples are used in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run; low flushes and idles the block |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| cfg_format | input | 2 | Framing style code |
| cfg_len | input | 3 | Data length code |
| cfg_slot24 | input | 1 | Request 24-bit slots for 18/20/24-bit data |
| cfg_slots_m1 | input | SLOT_IW | TDM slot count minus one |
| cfg_fsync | input | 2 | TDM frame-sync width code |
| cfg_hold_last | input | 1 | Underrun fill: 0 zero, 1 previous word |
| cfg_mono | input | 1 | Odd slots repeat the preceding even slot |
| cfg_loop | input | 1 | Route serial output to loop_out |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | 32 | Sample, right-aligned |
| smp_ready | output | 1 | Buffer can take a sample |
| ser_data | output | 1 | Serial data out |
| frame_ws | output | 1 | Word select / frame sync |
| loop_in | input | 1 | External serial data in |
| loop_out | output | 1 | Receive-side data line |
| underrun | output | 1 | One-cycle missing-sample pulse |
| underrun_slot | output | SLOT_IW | Slot number of the last underrun |

## Verification
The bench builds the block with its default MAX_SLOTS of 8, so every TDM slot count from one to eight can be reached. It sweeps all four formats against every length code, both slot widths, every slot count and every frame-sync code. For each bit tick it predicts the line values from position arithmetic, with word values derived from a hashed sample index. Short feeds with mono on and off, and with both underrun fill choices, reach the underrun and duplication corners, including an odd-sized TDM frame.

// File: rtl/tx_pkg.sv
// Shared constants, format encoding and length decoders for the serial
// audio transmitter. Assumes samples are at most SMP_W bits wide.
package tx_pkg;
    localparam int SMP_W = 32;
    localparam int BIT_IW = $clog2(SMP_W);
    localparam int LEN_W = BIT_IW + 1;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LJ    = 2'd1,
        FMT_TDM   = 2'd2,
        FMT_TDMLJ = 2'd3
    } tx_fmt_e;

    // Number of meaningful sample bits for a length code.
    function automatic logic [LEN_W-1:0] decode_len(input logic [2:0] code);
        case (code)
            3'd0:    return LEN_W'(32);
            3'd1:    return LEN_W'(24);
            3'd2:    return LEN_W'(20);
            3'd3:    return LEN_W'(18);
            3'd4,
            3'd5:    return LEN_W'(16);
            default: return LEN_W'(8);
        endcase
    endfunction

    // Bit periods per slot: narrow slots only for the mid-size lengths.
    function automatic logic [LEN_W-1:0] decode_slot(input logic [2:0] code,
                                                     input logic narrow);
        if (narrow && (code == 3'd1 || code == 3'd2 || code == 3'd3))
            return LEN_W'(24);
        return LEN_W'(32);
    endfunction

    // Formats whose data trails the slot position by one bit period.
    function automatic logic has_bit_delay(input tx_fmt_e f);
        return (f == FMT_I2S) || (f == FMT_TDM);
    endfunction
endpackage

// File: rtl/tx_frame_timer.sv
// Frame position counter. Tracks slot, bit-in-slot and bit-in-frame, and
// presents the position that the next tick will enter. Assumes the
// configuration is static while enable is high.
module tx_frame_timer
    import tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                bit_tick,
    input  logic                tdm_mode,
    input  logic [SLOT_IW-1:0]  slots_m1,
    input  logic [LEN_W-1:0]    slot_w,
    output logic                step,
    output logic                slot_begin,
    output logic [SLOT_IW-1:0]  nx_slot,
    output logic [BIT_IW-1:0]   nx_bit,
    output logic [POS_W-1:0]    nx_pos,
    output logic [POS_W:0]      frame_len
);
    localparam int SLOT_IW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
    localparam int POS_W = $clog2(MAX_SLOTS * SMP_W);

    logic                run_q;
    logic [SLOT_IW-1:0]  slot_q;
    logic [BIT_IW-1:0]   bit_q;
    logic [POS_W-1:0]    pos_q;
    logic [SLOT_IW-1:0]  last_slot;
    logic [POS_W:0]      slot_cnt;

    // Frame geometry from the static configuration.
    always_comb begin
        last_slot = tdm_mode ? slots_m1 : SLOT_IW'(1);
        slot_cnt  = (POS_W+1)'(last_slot) + (POS_W+1)'(1);
        frame_len = slot_cnt * (POS_W+1)'(slot_w);
    end

    // Next position: start of frame after enable, else advance one bit.
    always_comb begin
        nx_slot = slot_q;
        nx_bit  = bit_q + BIT_IW'(1);
        nx_pos  = pos_q + POS_W'(1);
        if (!run_q) begin
            nx_slot = '0;
            nx_bit  = '0;
            nx_pos  = '0;
        end else if ({1'b0, bit_q} == slot_w - LEN_W'(1)) begin
            nx_bit = '0;
            if (slot_q == last_slot) begin
                nx_slot = '0;
                nx_pos  = '0;
            end else begin
                nx_slot = slot_q + SLOT_IW'(1);
            end
        end
    end

    assign step       = enable && bit_tick;
    assign slot_begin = step && (nx_bit == '0);

    // Position registers move on every enabled tick and clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q  <= 1'b0;
            slot_q <= '0;
            bit_q  <= '0;
            pos_q  <= '0;
        end else if (bit_tick) begin
            run_q  <= 1'b1;
            slot_q <= nx_slot;
            bit_q  <= nx_bit;
            pos_q  <= nx_pos;
        end
    end
endmodule

// File: rtl/tx_sample_feed.sv
// Single-entry sample buffer plus slot word selection. At each slot start
// it takes the buffered sample, or fills with zero / the previous word on
// underrun; mono odd slots reuse the current word without taking one.
module tx_sample_feed
    import tx_pkg::*;
#(
    parameter int SLOT_IW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                slot_begin,
    input  logic [SLOT_IW-1:0]  nx_slot,
    input  logic                mono,
    input  logic                hold_last,
    input  logic                smp_valid,
    input  logic [SMP_W-1:0]    smp_data,
    output logic                smp_ready,
    output logic [SMP_W-1:0]    nx_word,
    output logic                underrun,
    output logic [SLOT_IW-1:0]  underrun_slot
);
    logic             hold_v;
    logic [SMP_W-1:0] hold_q;
    logic [SMP_W-1:0] cur_q;
    logic             consume;
    logic             starve;

    assign smp_ready = enable && !hold_v;
    assign consume   = slot_begin && !(mono && nx_slot[0]);
    assign starve    = consume && !hold_v;

    // Word for the position being entered.
    always_comb begin
        nx_word = cur_q;
        if (slot_begin && !(mono && nx_slot[0])) begin
            if (hold_v)
                nx_word = hold_q;
            else if (!hold_last)
                nx_word = '0;
        end
    end

    // Buffer: a slot start empties it, an accepted sample fills it.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else begin
            if (consume)
                hold_v <= 1'b0;
            if (smp_valid && smp_ready) begin
                hold_v <= 1'b1;
                hold_q <= smp_data;
            end
        end
    end

    // Current slot word; also the source for repeat and mono duplication.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cur_q <= '0;
        else
            cur_q <= nx_word;
    end

    // Underrun pulse and the slot it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            underrun      <= 1'b0;
            underrun_slot <= '0;
        end else begin
            underrun <= starve;
            if (starve)
                underrun_slot <= nx_slot;
        end
    end
endmodule

// File: rtl/tx_bit_driver.sv
// Output stage. Picks the bit for the position being entered, applies
// the one-bit delay for the delayed formats, and forms word select or
// frame sync. Both outputs are registered and move only on a tick.
module tx_bit_driver
    import tx_pkg::*;
#(
    parameter int SLOT_IW = 3,
    parameter int POS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                step,
    input  tx_fmt_e             fmt,
    input  logic [1:0]          fsync,
    input  logic [LEN_W-1:0]    data_len,
    input  logic [SLOT_IW-1:0]  nx_slot,
    input  logic [BIT_IW-1:0]   nx_bit,
    input  logic [POS_W-1:0]    nx_pos,
    input  logic [POS_W:0]      frame_len,
    input  logic [SMP_W-1:0]    nx_word,
    output logic                ser_data,
    output logic                frame_ws
);
    logic              bit_now;
    logic              bit_prev;
    logic              ws_now;
    logic [LEN_W-1:0]  idx;

    // MSB-first bit select with zero padding past the data length.
    always_comb begin
        idx     = data_len - LEN_W'(1) - {1'b0, nx_bit};
        bit_now = ({1'b0, nx_bit} < data_len) ? nx_word[idx[BIT_IW-1:0]] : 1'b0;
    end

    // Word select / frame sync level for the position being entered.
    always_comb begin
        case (fmt)
            FMT_I2S: ws_now = (nx_slot == SLOT_IW'(1));
            FMT_LJ:  ws_now = (nx_slot == '0);
            default: begin
                case (fsync)
                    2'd0:    ws_now = (nx_slot == '0);
                    2'd1:    ws_now = ({1'b0, nx_pos} < (frame_len >> 1));
                    default: ws_now = (nx_pos == '0);
                endcase
            end
        endcase
    end

    // Registered lines plus the one-bit delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ser_data <= 1'b0;
            frame_ws <= 1'b0;
            bit_prev <= 1'b0;
        end else if (step) begin
            ser_data <= has_bit_delay(fmt) ? bit_prev : bit_now;
            frame_ws <= ws_now;
            bit_prev <= bit_now;
        end
    end
endmodule

// File: rtl/tdm_serial_tx.sv
// Top level of the serial audio transmitter: frame timer, sample feed
// and bit driver, plus the loopback select. Assumes bit_tick comes from
// an external divider and the cfg_* inputs change only while disabled.
module tdm_serial_tx
    import tx_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_IW = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                bit_tick,
    input  logic [1:0]          cfg_format,
    input  logic [2:0]          cfg_len,
    input  logic                cfg_slot24,
    input  logic [SLOT_IW-1:0]  cfg_slots_m1,
    input  logic [1:0]          cfg_fsync,
    input  logic                cfg_hold_last,
    input  logic                cfg_mono,
    input  logic                cfg_loop,
    input  logic                smp_valid,
    input  logic [31:0]         smp_data,
    output logic                smp_ready,
    output logic                ser_data,
    output logic                frame_ws,
    input  logic                loop_in,
    output logic                loop_out,
    output logic                underrun,
    output logic [SLOT_IW-1:0]  underrun_slot
);
    localparam int POS_W = $clog2(MAX_SLOTS * SMP_W);

    tx_fmt_e             fmt;
    logic [LEN_W-1:0]    data_len;
    logic [LEN_W-1:0]    slot_w;
    logic                step;
    logic                slot_begin;
    logic [SLOT_IW-1:0]  nx_slot;
    logic [BIT_IW-1:0]   nx_bit;
    logic [POS_W-1:0]    nx_pos;
    logic [POS_W:0]      frame_len;
    logic [SMP_W-1:0]    nx_word;

    assign fmt      = tx_fmt_e'(cfg_format);
    assign data_len = decode_len(cfg_len);
    assign slot_w   = decode_slot(cfg_len, cfg_slot24);

    tx_frame_timer #(.MAX_SLOTS(MAX_SLOTS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bit_tick   (bit_tick),
        .tdm_mode   (cfg_format[1]),
        .slots_m1   (cfg_slots_m1),
        .slot_w     (slot_w),
        .step       (step),
        .slot_begin (slot_begin),
        .nx_slot    (nx_slot),
        .nx_bit     (nx_bit),
        .nx_pos     (nx_pos),
        .frame_len  (frame_len)
    );

    tx_sample_feed #(.SLOT_IW(SLOT_IW)) u_feed (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .slot_begin    (slot_begin),
        .nx_slot       (nx_slot),
        .mono          (cfg_mono),
        .hold_last     (cfg_hold_last),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .smp_ready     (smp_ready),
        .nx_word       (nx_word),
        .underrun      (underrun),
        .underrun_slot (underrun_slot)
    );

    tx_bit_driver #(.SLOT_IW(SLOT_IW), .POS_W(POS_W)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .step      (step),
        .fmt       (fmt),
        .fsync     (cfg_fsync),
        .data_len  (data_len),
        .nx_slot   (nx_slot),
        .nx_bit    (nx_bit),
        .nx_pos    (nx_pos),
        .frame_len (frame_len),
        .nx_word   (nx_word),
        .ser_data  (ser_data),
        .frame_ws  (frame_ws)
    );

    // Receive-side line: internal loopback or the external pin.
    assign loop_out = cfg_loop ? ser_data : loop_in;
endmodule

// File: rtl/tx_chk.sv
// Protocol checker for tdm_serial_tx, attached by bind below.
module tx_chk #(
    parameter int SLOT_IW = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                bit_tick,
    input logic [1:0]          cfg_format,
    input logic [SLOT_IW-1:0]  cfg_slots_m1,
    input logic                cfg_mono,
    input logic                smp_valid,
    input logic                smp_ready,
    input logic                ser_data,
    input logic                frame_ws,
    input logic                underrun,
    input logic [SLOT_IW-1:0]  underrun_slot
);
    // R11
    ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !smp_ready);

    // R11
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ser_data && !frame_ws && !underrun));

    // R1
    tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_tick) |=> ($stable(ser_data) && $stable(frame_ws)));

    // R8
    unf_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> !underrun);

    // R8
    unf_slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> ((cfg_format[1] && underrun_slot <= cfg_slots_m1) ||
                      (!cfg_format[1] && underrun_slot <= SLOT_IW'(1))));

    // R9
    mono_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && cfg_mono) |-> !underrun_slot[0]);

    // R12
    one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready) |=> !smp_ready);
endmodule

bind tdm_serial_tx tx_chk #(.SLOT_IW(SLOT_IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .bit_tick      (bit_tick),
    .cfg_format    (cfg_format),
    .cfg_slots_m1  (cfg_slots_m1),
    .cfg_mono      (cfg_mono),
    .smp_valid     (smp_valid),
    .smp_ready     (smp_ready),
    .ser_data      (ser_data),
    .frame_ws      (frame_ws),
    .underrun      (underrun),
    .underrun_slot (underrun_slot)
);

// File: tb/tb_tdm_serial_tx.sv
`timescale 1ns/1ps
module tb_tdm_serial_tx;
    localparam int MAX_SLOTS = 8;
    localparam int SLOT_IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic bit_tick = 1'b0;
    logic [1:0] cfg_format = '0;
    logic [2:0] cfg_len = '0;
    logic cfg_slot24 = 1'b0;
    logic [SLOT_IW-1:0] cfg_slots_m1 = '0;
    logic [1:0] cfg_fsync = '0;
    logic cfg_hold_last = 1'b0;
    logic cfg_mono = 1'b0;
    logic cfg_loop = 1'b0;
    logic smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic loop_in = 1'b0;
    logic smp_ready, ser_data, frame_ws, loop_out, underrun;
    logic [SLOT_IW-1:0] underrun_slot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int idx = 0;
    int limit = 0;
    bit xfer = 1'b0;

    always #10 clk = ~clk;

    tdm_serial_tx #(.MAX_SLOTS(MAX_SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_tick(bit_tick),
        .cfg_format(cfg_format), .cfg_len(cfg_len), .cfg_slot24(cfg_slot24),
        .cfg_slots_m1(cfg_slots_m1), .cfg_fsync(cfg_fsync),
        .cfg_hold_last(cfg_hold_last), .cfg_mono(cfg_mono), .cfg_loop(cfg_loop),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .ser_data(ser_data), .frame_ws(frame_ws), .loop_in(loop_in),
        .loop_out(loop_out), .underrun(underrun), .underrun_slot(underrun_slot)
    );

    function automatic logic [31:0] pat(input int c);
        return (32'(c) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
    endfunction

    function automatic int len_of(input int code);
        case (code)
            0: return 32; 1: return 24; 2: return 20; 3: return 18;
            4, 5: return 16; default: return 8;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int t,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d got=%0h exp=%0h", tag, t, act, exp);
        end
    endtask

    // Offer the next sample; count the one accepted at the last edge.
    task automatic feed_step();
        if (xfer) idx++;
        smp_valid = (idx < limit);
        smp_data  = pat(idx);
        xfer      = smp_valid && smp_ready;
    endtask

    // One configuration: idle check, prefill, then per-tick comparison.
    task automatic run_cfg(input int fmt, input int len, input int s24,
                           input int nm1, input int fs, input int hl,
                           input int mo, input int lim, input int frames,
                           input int lp, input string tag);
        int ns, sw, fl, ln, f, p, s, b, g, c, tp;
        logic [31:0] w;
        bit und_now, und_prev, exp_sd, exp_ws, exp_unf, exp_lp;
        @(negedge clk);
        enable = 1'b0; bit_tick = 1'b0;
        cfg_format = 2'(fmt); cfg_len = 3'(len); cfg_slot24 = s24[0];
        cfg_slots_m1 = 3'(nm1); cfg_fsync = 2'(fs); cfg_hold_last = hl[0];
        cfg_mono = mo[0]; cfg_loop = lp[0];
        idx = 0; limit = lim; xfer = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        // R11: disabled lines low, not ready
        chk(!ser_data && !frame_ws && !smp_ready && !underrun, "R11", -1,
            {ser_data, frame_ws, smp_ready, underrun}, 0);
        enable = 1'b1;
        repeat (4) begin @(negedge clk); feed_step(); end
        // R12: buffer full after the prefill, so ready drops
        if (lim > 0) chk(!smp_ready, "R12", -1, int'(smp_ready), 0);
        ns = (fmt >= 2) ? nm1 + 1 : 2;
        ln = len_of(len);
        sw = (s24 != 0 && len >= 1 && len <= 3) ? 24 : 32;
        fl = ns * sw;
        und_prev = 1'b0;
        for (int t = 0; t < frames * fl; t++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            loop_in = t[0];
            feed_step();
            @(negedge clk);
            f = t / fl; p = t % fl; s = p / sw; b = p % sw;
            g = f * ns + s;
            c = (mo != 0) ? g / 2 : g;
            if (c < lim) w = pat(c);
            else if (hl != 0 && lim > 0) w = pat(lim - 1);
            else w = '0;
            und_now = (b < ln) ? w[ln - 1 - b] : 1'b0;
            exp_sd = (fmt == 0 || fmt == 2) ? und_prev : und_now;
            und_prev = und_now;
            if (fmt == 0) exp_ws = (s == 1);
            else if (fmt == 1) exp_ws = (s == 0);
            else if (fs == 0) exp_ws = (s == 0);
            else if (fs == 1) exp_ws = (p < fl / 2);
            else exp_ws = (p == 0);
            exp_unf = (b == 0) && (mo == 0 || s % 2 == 0) && (c >= lim);
            exp_lp = (lp != 0) ? exp_sd : t[0];
            chk(ser_data == exp_sd, tag, t, int'(ser_data), int'(exp_sd));
            chk(frame_ws == exp_ws, (fmt >= 2) ? "R3" : "R2", t,
                int'(frame_ws), int'(exp_ws));
            chk(underrun == exp_unf, "R8", t, int'(underrun), int'(exp_unf));
            if (exp_unf)
                chk(int'(underrun_slot) == s, "R8", t, int'(underrun_slot), s);
            chk(loop_out == exp_lp, "R10", t, int'(loop_out), int'(exp_lp));
            bit_tick = 1'b0;
            feed_step();
        end
        tp = 0;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        // R11: dropping enable parks the lines
        chk(!ser_data && !frame_ws && !smp_ready, "R11", tp,
            {ser_data, frame_ws, smp_ready}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!ser_data && !frame_ws && !smp_ready && !underrun, "R11", -1,
            {ser_data, frame_ws, smp_ready, underrun}, 0);
        rst_n = 1'b1;
        // R1 R2 R4 R5: stereo formats, every length code, both slot widths;
        // the slot-count field is set to 5 to show it is ignored (R6)
        for (int fm = 0; fm < 2; fm++)
            for (int ln = 0; ln < 8; ln++)
                for (int sn = 0; sn < 2; sn++)
                    run_cfg(fm, ln, sn, 5, 1, 0, 0, 1000, 2, sn, "R4");
        // R1 R3 R6: both TDM formats, every slot count and frame-sync code
        for (int fm = 2; fm < 4; fm++)
            for (int nm = 0; nm < 8; nm++)
                for (int fs = 0; fs < 4; fs++)
                    run_cfg(fm, (nm + fs) % 8, nm % 2, nm, fs, 0, 0, 1000, 2,
                            fs % 2, "R6");
        // R9: mono duplication in stereo and TDM
        run_cfg(0, 4, 0, 0, 0, 0, 1, 1000, 3, 0, "R9");
        run_cfg(1, 1, 1, 0, 0, 0, 1, 1000, 3, 1, "R9");
        run_cfg(2, 6, 0, 3, 0, 0, 1, 1000, 2, 0, "R9");
        run_cfg(3, 0, 0, 7, 2, 0, 1, 1000, 2, 0, "R9");
        // R7 R8: underrun fill, zero and repeat, stereo and odd TDM frame
        run_cfg(0, 4, 0, 0, 0, 0, 0, 3, 3, 0, "R7");
        run_cfg(0, 4, 0, 0, 0, 1, 0, 3, 3, 1, "R7");
        run_cfg(2, 2, 1, 2, 1, 0, 0, 4, 3, 0, "R7");
        run_cfg(3, 0, 0, 2, 0, 1, 0, 4, 3, 0, "R7");
        run_cfg(1, 6, 0, 0, 0, 1, 0, 0, 2, 0, "R7");
        // R9 R7: mono with starvation
        run_cfg(1, 4, 0, 0, 0, 0, 1, 2, 4, 0, "R9");
        run_cfg(1, 4, 0, 0, 0, 1, 1, 2, 4, 0, "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete got=0 exp=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule